// File: doc/BRIEF.md
# Multi-mode addressable bit latch

This block holds eight single-bit storage cells behind one data input and a three-bit address. Two active-low controls, an enable and a clear, choose one of four modes. In the write mode the single data bit goes into the chosen cell. In the hold mode nothing changes. In the demultiplex mode the chosen output carries the data bit and every other output goes low. In the clear mode all outputs are zeroed. With the data bit tied high, the demultiplex mode turns the block into a 3-to-8 one-hot decoder. Driving a run of write cycles with a stepping address loads a parallel word one bit at a time.

The block is a clocked version of the usual level-sensitive latch. Every input is sampled on the rising clock edge and the outputs come from registers, so an output change appears one edge after the inputs that cause it. There is no combinational path from any input to any output. A synchronous active-low power-on reset, separate from the functional clear, zeroes the cells. A registered guard flag rises when two write cycles in a row use addresses that differ in more than one bit, because such a change is only safe while holding.

Top module: `bitLatchBank`

## Requirements
- R1: In write mode (enN=0, clrN=1), the address value n selects output bit q[n], where address 0 is q[0] and address 7 is q[7]. After the next rising edge, that bit equals the sampled data input.
- R2: In write mode, every bit other than the addressed one keeps its previous value.
- R3: In hold mode (enN=1, clrN=1), all eight bits keep their values whatever the data and address inputs are.
- R4: In demultiplex mode (enN=0, clrN=0), the addressed bit takes the data input and all other bits go to 0. With data at 1, the output is the one-hot decode of the address.
- R5: In clear mode (enN=1, clrN=0), all bits go to 0 regardless of the address and data inputs.
- R6: Outputs change only on a rising clock edge, one edge after the inputs are sampled. A change of an input between edges does not reach the outputs.
- R7: The stored state is updated by demultiplex mode. After a demultiplex cycle, a hold keeps the one-hot or all-zero pattern that the demultiplex cycle left.
- R8: While rstN is 0 at a rising edge, all bits and the guard flag become 0, overriding every mode.
- R9: addrGlitch is 1 after an edge exactly when that cycle and the cycle before it were both write mode outside reset, and their addresses differ in more than one bit. Otherwise it is 0.
- R10: When several write cycles to the same bit precede a switch to hold, the bit keeps the data value of the last write cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous active-low power-on reset |
| dataIn | input | 1 | Single data bit |
| addr | input | 3 | Selects the output bit |
| enN | input | 1 | Active-low enable, one of the two mode controls |
| clrN | input | 1 | Active-low clear, the other mode control |
| q | output | 8 | Registered parallel outputs |
| addrGlitch | output | 1 | Registered flag for an address change of more than one bit between write cycles |

## Verification
The checker watches every cycle for the one-edge rules of each mode: the written bit, the untouched neighbours, a stable hold, the one-hot demultiplex pattern, clear, reset, and the guard flag set and cleared in both directions. Some effects need a chain of cycles to show. These are the retention of the last write before a hold, a demultiplex pattern surviving into hold, and inputs moving between edges without reaching the outputs. The bench scenarios cover these chains, and a random mode sequence is compared against an independent model.

// File: rtl/bitLatchPkg.sv
package bitLatchPkg;
  // mode code is {enN, clrN}
  typedef enum logic [1:0] {
    MODE_DEMUX = 2'b00,
    MODE_WRITE = 2'b01,
    MODE_CLEAR = 2'b10,
    MODE_HOLD  = 2'b11
  } modeT;

  typedef struct packed {
    logic load;      // addressed bit takes data
    logic zeroRest;  // non-addressed bits go low
    logic zeroAll;   // every bit goes low
  } strobeT;
endpackage

// File: rtl/bitLatchCtrl.sv
module bitLatchCtrl
  import bitLatchPkg::*;
#(
  parameter int NUM_BITS = 8,
  localparam int ADDR_W = $clog2(NUM_BITS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enN,
  input  logic              clrN,
  input  logic [ADDR_W-1:0] addr,
  output strobeT            strobe,
  output logic              addrGlitch
);
  modeT mode;
  logic [ADDR_W-1:0] prevAddr;
  logic prevWrite;
  logic isWrite;
  logic multiFlip;

  assign mode    = modeT'({enN, clrN});
  assign isWrite = (mode == MODE_WRITE);

  always_comb begin
    strobe = '0;
    unique case (mode)
      MODE_WRITE: strobe.load = 1'b1;
      MODE_DEMUX: begin
        strobe.load     = 1'b1;
        strobe.zeroRest = 1'b1;
      end
      MODE_CLEAR: strobe.zeroAll = 1'b1;
      default: ;
    endcase
    if (!rstN) strobe = '{load: 1'b0, zeroRest: 1'b0, zeroAll: 1'b1};
  end

  assign multiFlip = $countones(addr ^ prevAddr) > 1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevAddr   <= '0;
      prevWrite  <= 1'b0;
      addrGlitch <= 1'b0;
    end else begin
      prevAddr   <= addr;
      prevWrite  <= isWrite;
      addrGlitch <= isWrite && prevWrite && multiFlip;
    end
  end
endmodule

// File: rtl/bitLatchPath.sv
module bitLatchPath
  import bitLatchPkg::*;
#(
  parameter int NUM_BITS = 8,
  localparam int ADDR_W = $clog2(NUM_BITS)
) (
  input  logic                clk,
  input  logic                dataIn,
  input  logic [ADDR_W-1:0]   addr,
  input  strobeT              strobe,
  output logic [NUM_BITS-1:0] q
);
  for (genvar i = 0; i < NUM_BITS; i++) begin : gBit
    logic hit;
    assign hit = (addr == ADDR_W'(i));
    always_ff @(posedge clk) begin
      if (strobe.zeroAll)           q[i] <= 1'b0;
      else if (strobe.load && hit)  q[i] <= dataIn;
      else if (strobe.zeroRest)     q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/bitLatchBank.sv
module bitLatchBank
  import bitLatchPkg::*;
#(
  parameter int NUM_BITS = 8,
  localparam int ADDR_W = $clog2(NUM_BITS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                dataIn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                enN,
  input  logic                clrN,
  output logic [NUM_BITS-1:0] q,
  output logic                addrGlitch
);
  strobeT strobe;

  bitLatchCtrl #(.NUM_BITS(NUM_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .enN(enN), .clrN(clrN), .addr(addr),
    .strobe(strobe), .addrGlitch(addrGlitch)
  );

  bitLatchPath #(.NUM_BITS(NUM_BITS)) u_path (
    .clk(clk), .dataIn(dataIn), .addr(addr), .strobe(strobe), .q(q)
  );
endmodule

// File: rtl/bitLatchChecker.sv
module bitLatchChecker #(
  parameter int NUM_BITS = 8,
  localparam int ADDR_W = $clog2(NUM_BITS)
) (
  input logic                clk,
  input logic                rstN,
  input logic                dataIn,
  input logic [ADDR_W-1:0]   addr,
  input logic                enN,
  input logic                clrN,
  input logic [NUM_BITS-1:0] q,
  input logic                addrGlitch
);
  logic wrMode, holdMode, dmxMode, clrMode;
  assign wrMode   = !enN &&  clrN;
  assign holdMode =  enN &&  clrN;
  assign dmxMode  = !enN && !clrN;
  assign clrMode  =  enN && !clrN;

  assert_write_bit_R1: assert property (@(posedge clk) disable iff (!rstN)
    wrMode |=> q[$past(addr)] == $past(dataIn));

  assert_write_others_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrMode |=> ((q ^ $past(q)) & ~(NUM_BITS'(1) << $past(addr))) == '0);

  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    holdMode |=> $stable(q));

  assert_demux_pattern_R4: assert property (@(posedge clk) disable iff (!rstN)
    dmxMode |=> q == ($past(dataIn) ? (NUM_BITS'(1) << $past(addr)) : '0));

  assert_clear_all_R5: assert property (@(posedge clk) disable iff (!rstN)
    clrMode |=> q == '0);

  assert_reset_zero_R8: assert property (@(posedge clk)
    !rstN |=> (q == '0) && !addrGlitch);

  assert_glitch_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrMode && $past(rstN) && !$past(enN) && $past(clrN)
     && ($countones(addr ^ $past(addr)) > 1)) |=> addrGlitch);

  assert_glitch_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(wrMode && $past(rstN) && !$past(enN) && $past(clrN)
      && ($countones(addr ^ $past(addr)) > 1)) |=> !addrGlitch);
endmodule

bind bitLatchBank bitLatchChecker #(.NUM_BITS(NUM_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .dataIn(dataIn), .addr(addr), .enN(enN),
  .clrN(clrN), .q(q), .addrGlitch(addrGlitch)
);

// File: tb/bitLatchBank_bench.sv
`timescale 1ns/1ps
module bitLatchBank_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dataIn = 1'b0;
  logic [2:0] addr = '0;
  logic enN = 1'b1;
  logic clrN = 1'b1;
  logic [7:0] q;
  logic addrGlitch;

  int errors = 0;
  int checks = 0;

  // reference model state
  logic [7:0] mq = '0;
  logic [2:0] mPrevA = '0;
  logic mPrevW = 1'b0;
  logic mFlag = 1'b0;

  always #2.5 clk = ~clk;

  bitLatchBank u_bitLatchBank (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .addr(addr), .enN(enN),
    .clrN(clrN), .q(q), .addrGlitch(addrGlitch)
  );

  // vector: {enN, clrN, addr[2:0], data, expQ[7:0], expFlag}
  localparam logic [14:0] VEC [16] = '{
    {1'b0, 1'b1, 3'd0, 1'b1, 8'h01, 1'b0},  // R1 write bit 0
    {1'b0, 1'b1, 3'd1, 1'b1, 8'h03, 1'b0},  // R2 neighbours kept
    {1'b0, 1'b1, 3'd7, 1'b1, 8'h83, 1'b1},  // R9 two address bits flip
    {1'b1, 1'b1, 3'd2, 1'b1, 8'h83, 1'b0},  // R3 hold ignores inputs
    {1'b0, 1'b1, 3'd0, 1'b0, 8'h82, 1'b0},  // R1 write 0
    {1'b0, 1'b1, 3'd0, 1'b1, 8'h83, 1'b0},  // R10 repeated writes
    {1'b0, 1'b1, 3'd0, 1'b0, 8'h82, 1'b0},  // R10 last write
    {1'b1, 1'b1, 3'd5, 1'b1, 8'h82, 1'b0},  // R10 hold keeps last write
    {1'b0, 1'b0, 3'd5, 1'b1, 8'h20, 1'b0},  // R4 decoder one-hot
    {1'b1, 1'b1, 3'd3, 1'b0, 8'h20, 1'b0},  // R7 hold after demux
    {1'b0, 1'b0, 3'd3, 1'b0, 8'h00, 1'b0},  // R4 demux with data 0
    {1'b0, 1'b0, 3'd4, 1'b1, 8'h10, 1'b0},  // R4 demux bit 4
    {1'b1, 1'b0, 3'd7, 1'b1, 8'h00, 1'b0},  // R5 clear ignores inputs
    {1'b0, 1'b1, 3'd2, 1'b1, 8'h04, 1'b0},  // R9 no flag after clear
    {1'b0, 1'b1, 3'd5, 1'b1, 8'h24, 1'b1},  // R9 three bits flip
    {1'b0, 1'b1, 3'd4, 1'b1, 8'h34, 1'b0}   // R9 one bit flips
  };

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual q=%h flag=%b expected q=%h flag=%b",
               req, act[8:1], act[0], exp[8:1], exp[0]);
    end
  endtask

  task automatic modelStep(input logic r, input logic e, input logic c,
                           input logic [2:0] a, input logic d);
    logic w;
    w = !e && c;
    if (!r) begin
      mq = '0; mPrevA = '0; mPrevW = 1'b0; mFlag = 1'b0;
    end else begin
      mFlag = w && mPrevW && ($countones(a ^ mPrevA) > 1);
      if (e && !c) mq = '0;
      else if (!e && !c) mq = d ? (8'd1 << a) : 8'd0;
      else if (!e && c) mq[a] = d;
      mPrevA = a; mPrevW = w;
    end
  endtask

  function automatic string modeTag(input logic r, input logic e, input logic c);
    if (!r) return "R8";
    case ({e, c})
      2'b01: return "R2";
      2'b11: return "R3";
      2'b00: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic step(input logic r, input logic e, input logic c,
                      input logic [2:0] a, input logic d);
    @(negedge clk);
    rstN = r; enN = e; clrN = c; addr = a; dataIn = d;
    @(posedge clk);
    #1;
    modelStep(r, e, c, a, d);
    chk({modeTag(r, e, c), "/R9 model"}, {q, addrGlitch}, {mq, mFlag});
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(1'b0, 1'b1, 1'b1, 3'd0, 1'b0);
    step(1'b0, 1'b0, 1'b1, 3'd3, 1'b1);
    chk("R8 reset state", {q, addrGlitch}, 9'h0);

    for (int i = 0; i < 16; i++) begin
      step(1'b1, VEC[i][14], VEC[i][13], VEC[i][12:10], VEC[i][9]);
      chk($sformatf("vector %0d R1/R2/R3/R4/R5/R7/R9/R10", i),
          {q, addrGlitch}, VEC[i][8:0]);
    end

    // R6: inputs changed between edges do not reach outputs early
    @(negedge clk);
    enN = 1'b0; clrN = 1'b0; addr = 3'd0; dataIn = 1'b1;
    #1;
    chk("R6 before edge", {q, addrGlitch}, {8'h34, 1'b0});
    addr = 3'd6;
    @(posedge clk);
    #1;
    modelStep(1'b1, 1'b0, 1'b0, 3'd6, 1'b1);
    chk("R6 after edge", {q, addrGlitch}, {8'h40, 1'b0});

    // decoder sweep across all addresses (R4, R1 mapping)
    for (int a = 0; a < 8; a++) begin
      step(1'b1, 1'b0, 1'b0, 3'(a), 1'b1);
      chk("R4 decode sweep", {q, addrGlitch}, {8'd1 << a, 1'b0});
    end

    // R8 reset overrides a write in progress
    step(1'b1, 1'b0, 1'b1, 3'd0, 1'b1);
    step(1'b0, 1'b0, 1'b1, 3'd3, 1'b1);
    chk("R8 reset over write", {q, addrGlitch}, 9'h0);

    // random sequence against the model
    for (int n = 0; n < 400; n++) begin
      step(($urandom_range(0, 39) != 0), 1'($urandom), 1'($urandom),
           3'($urandom), 1'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule